// File: doc/BRIEF.md
# Parallel Flash Host Bus Front End

This block sits between the asynchronous host pins of a parallel NOR-style flash model and its clocked internals. A free-running system clock samples chip select, output enable, write strobe, pin reset and the bus-width select through multi-stage synchronizers. The block decides from the synchronized pins whether the data bus is driven. It reports the output enables per bit, so the tristate buffers themselves stay outside.

On each accepted host write, the block takes the address when the later of the two strobes falls. It takes the data when the earlier of the two strobes rises. It then raises a one-cycle strobe toward the command logic, carrying the address, the data and a 2-bit sector index. A lockout input from the command logic suppresses strobes aimed at the boot sector. A static parameter picks whether the boot sector sits at the top or the bottom of the word address space.

In narrow mode only the low data byte carries data. The top data pin then acts as the byte-select address bit below the word address.

Top module: `pflash_bus_front`

## Requirements
- R1: While pin reset is high, chip select low, output enable low and write strobe high, the block enables all 16 data outputs in word mode. It drives them with `rd_data`, fetched from word address `rd_addr`, which equals the address pins.
- R2: While chip select or output enable is high, or the write strobe is low, or pin reset is low, `dq_oe` is 0.
- R3: A write cycle produces exactly one `wr_valid` pulse. A write cycle runs with output enable high, and ends when the first strobe rises after both chip select and write strobe were low. A cycle with output enable low produces none. The cycle may be controlled by write strobe or by chip select.
- R4: `wr_addr` is the address present when the later of chip select and write strobe fell. Address changes after that point do not affect it.
- R5: `wr_data` is the data present when the earlier of the two strobes rose. Data changes after that point do not affect it.
- R6: With `word_sel` low, the block runs in byte mode. `dq_oe` is 0x00FF during reads. `dq_out[7:0]` carries `rd_data[15:8]` when `dq_in[15]` is 1 and `rd_data[7:0]` when it is 0. Writes report `wr_byte`=1 and `wr_lsb`=`dq_in[15]`, with `wr_data[15:8]`=0.
- R7: In bottom-boot layout (TOP_BOOT=0), the sector index is as follows, with the encoding 0 boot, 1 first parameter, 2 second parameter, 3 main:
  - word addresses 0x00000–0x01FFF map to 0;
  - 0x02000–0x02FFF map to 1;
  - 0x03000–0x03FFF map to 2;
  - 0x04000–0x7FFFF map to 3.
- R8: In top-boot layout (TOP_BOOT=1), the sector index uses the same encoding:
  - 0x7E000–0x7FFFF map to 0;
  - 0x7D000–0x7DFFF map to 1;
  - 0x7C000–0x7CFFF map to 2;
  - 0x00000–0x7BFFF map to 3.
- R9: While `boot_lock` is 1, a write whose captured address lies in sector 0 produces no pulse. Writes to other sectors still pulse.
- R10: Pin reset low aborts a write cycle in progress, so that cycle never pulses. After release, the block is in read/standby with reads working.
- R11: `wr_valid` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ce_n | input | 1 | Host chip select, active low, asynchronous |
| oe_n | input | 1 | Host output enable, active low, asynchronous |
| we_n | input | 1 | Host write strobe, active low, asynchronous |
| pin_rst_n | input | 1 | Host reset pin, active low, asynchronous |
| word_sel | input | 1 | 1 = 16-bit bus, 0 = byte bus |
| addr_pin | input | 19 | Host word address pins |
| dq_in | input | 16 | Host data bus inputs (bit 15 is byte select in byte mode) |
| dq_out | output | 16 | Data bus output values |
| dq_oe | output | 16 | Per-bit output enables for the data bus |
| rd_addr | output | 19 | Synchronized word address toward storage |
| rd_data | input | 16 | Word read from storage at rd_addr |
| rd_sector | output | 2 | Sector index of rd_addr |
| boot_lock | input | 1 | Boot-sector write lockout from command logic |
| wr_valid | output | 1 | One-cycle accepted-write strobe |
| wr_addr | output | 19 | Captured write word address |
| wr_lsb | output | 1 | Captured byte select (0 in word mode) |
| wr_byte | output | 1 | Write was a byte-mode write |
| wr_data | output | 16 | Captured write data |
| wr_sector | output | 2 | Sector index of wr_addr |

## Verification
The properties take for granted that the host holds the address and data pins stable for at least the synchronizer depth plus one clock around each strobe edge. They also take for granted that `boot_lock` changes only in step with the system clock. Under those conditions the synchronized copies line up, and the pin sample behind each captured value is well defined. The directed stimulus changes one pin group at a time and waits four clocks between changes, so every edge is seen by all synchronized copies in the same cycle. Reset is asserted only while the strobes are in a known state.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

   typedef enum logic [1:0] {
      SEC_BOOT = 2'd0,
      SEC_PAR1 = 2'd1,
      SEC_PAR2 = 2'd2,
      SEC_MAIN = 2'd3
   } sector_e;

   // bit positions inside the synchronized control vector
   localparam int CTL_CE   = 0;
   localparam int CTL_OE   = 1;
   localparam int CTL_WE   = 2;
   localparam int CTL_RST  = 3;
   localparam int CTL_WORD = 4;
   localparam int CTL_W    = 5;

endpackage

// File: rtl/pflash_sync.sv
module pflash_sync #(
   parameter int       W       = 1,
   parameter int       STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pflash_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= RST_VAL;
      else        st[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[i] <= RST_VAL;
         else        st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/pflash_sector_map.sv
module pflash_sector_map
   import pflash_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int BOOT_WORDS  = 8192,
   parameter int PARAM_WORDS = 4096,
   parameter bit TOP_BOOT    = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output sector_e           sector
);
   localparam int DEPTH = 1 << ADDR_W;

   if (BOOT_WORDS + 2 * PARAM_WORDS >= DEPTH) begin : g_bad_map
      $error("pflash_sector_map: boot and parameter sectors exceed address space");
   end

   if (TOP_BOOT) begin : g_top
      localparam logic [ADDR_W-1:0] BOOT_LO = ADDR_W'(DEPTH - BOOT_WORDS);
      localparam logic [ADDR_W-1:0] P1_LO   = ADDR_W'(DEPTH - BOOT_WORDS - PARAM_WORDS);
      localparam logic [ADDR_W-1:0] P2_LO   = ADDR_W'(DEPTH - BOOT_WORDS - 2 * PARAM_WORDS);
      always_comb begin
         if      (addr >= BOOT_LO) sector = SEC_BOOT;
         else if (addr >= P1_LO)   sector = SEC_PAR1;
         else if (addr >= P2_LO)   sector = SEC_PAR2;
         else                      sector = SEC_MAIN;
      end
   end else begin : g_bottom
      localparam logic [ADDR_W-1:0] P1_LO   = ADDR_W'(BOOT_WORDS);
      localparam logic [ADDR_W-1:0] P2_LO   = ADDR_W'(BOOT_WORDS + PARAM_WORDS);
      localparam logic [ADDR_W-1:0] MAIN_LO = ADDR_W'(BOOT_WORDS + 2 * PARAM_WORDS);
      always_comb begin
         if      (addr < P1_LO)   sector = SEC_BOOT;
         else if (addr < P2_LO)   sector = SEC_PAR1;
         else if (addr < MAIN_LO) sector = SEC_PAR2;
         else                     sector = SEC_MAIN;
      end
   end
endmodule

// File: rtl/pflash_rd_path.sv
module pflash_rd_path #(
   parameter int DATA_W = 16
) (
   input  logic              clr,
   input  logic              ce_s,
   input  logic              oe_s,
   input  logic              we_s,
   input  logic              word_s,
   input  logic              lsb_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] dq_oe
);
   localparam int HALF = DATA_W / 2;

   logic            rd_en;
   logic [HALF-1:0] lane;

   assign rd_en = !clr && !ce_s && !oe_s && we_s;
   assign lane  = lsb_s ? rd_data[DATA_W-1:HALF] : rd_data[HALF-1:0];

   // low lane always used, high lane only on the wide bus
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b < HALF) begin : g_lo
         assign dq_oe[b]  = rd_en;
         assign dq_out[b] = word_s ? rd_data[b] : lane[b];
      end else begin : g_hi
         assign dq_oe[b]  = rd_en && word_s;
         assign dq_out[b] = word_s && rd_data[b];
      end
   end
endmodule

// File: rtl/pflash_wr_capture.sv
module pflash_wr_capture
   import pflash_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ce_s,
   input  logic              oe_s,
   input  logic              we_s,
   input  logic              word_s,
   input  logic              lsb_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] dq_s,
   input  logic              boot_lock,
   input  sector_e           cap_sector,
   output logic [ADDR_W-1:0] cap_addr,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              wr_lsb,
   output logic              wr_byte,
   output logic [DATA_W-1:0] wr_data,
   output sector_e           wr_sector
);
   localparam int HALF = DATA_W / 2;

   logic strobe, strobe_q, fall, rise, armed, cap_lsb, blocked;
   logic [DATA_W-1:0] data_sel;

   // combined strobe is low only while both pins are low
   assign strobe  = ce_s | we_s;
   assign fall    = strobe_q && !strobe;
   assign rise    = !strobe_q && strobe;
   assign blocked = boot_lock && (cap_sector == SEC_BOOT);
   assign data_sel = word_s ? dq_s : {{HALF{1'b0}}, dq_s[HALF-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b1;
         armed    <= 1'b0;
         cap_addr <= '0;
         cap_lsb  <= 1'b0;
      end else if (clr) begin
         strobe_q <= 1'b1;
         armed    <= 1'b0;
      end else begin
         strobe_q <= strobe;
         if (fall) begin
            armed    <= oe_s;
            cap_addr <= addr_s;
            cap_lsb  <= lsb_s;
         end else if (rise || !oe_s) begin
            armed <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid  <= 1'b0;
         wr_addr   <= '0;
         wr_lsb    <= 1'b0;
         wr_byte   <= 1'b0;
         wr_data   <= '0;
         wr_sector <= SEC_BOOT;
      end else begin
         wr_valid <= !clr && rise && armed && oe_s && !blocked;
         if (!clr && rise && armed) begin
            wr_addr   <= cap_addr;
            wr_lsb    <= !word_s && cap_lsb;
            wr_byte   <= !word_s;
            wr_data   <= data_sel;
            wr_sector <= cap_sector;
         end
      end
   end
endmodule

// File: rtl/pflash_bus_front.sv
module pflash_bus_front
   import pflash_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int DATA_W      = 16,
   parameter int BOOT_WORDS  = 8192,
   parameter int PARAM_WORDS = 4096,
   parameter bit TOP_BOOT    = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              pin_rst_n,
   input  logic              word_sel,
   input  logic [ADDR_W-1:0] addr_pin,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] dq_oe,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rd_sector,
   input  logic              boot_lock,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              wr_lsb,
   output logic              wr_byte,
   output logic [DATA_W-1:0] wr_data,
   output logic [1:0]        wr_sector
);
   localparam int BUS_W = ADDR_W + DATA_W;
   localparam logic [CTL_W-1:0] CTL_IDLE = CTL_W'(5'b10111);

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_data
      $error("pflash_bus_front: DATA_W must be even and at least 4");
   end
   if (ADDR_W < 8 || ADDR_W > 30) begin : g_bad_addr
      $error("pflash_bus_front: ADDR_W out of range");
   end

   logic [CTL_W-1:0] ctl_raw, ctl_s;
   logic [BUS_W-1:0] bus_raw, bus_s;
   logic ce_s, oe_s, we_s, rp_s, word_s, lsb_s, clr;
   logic [ADDR_W-1:0] addr_s, cap_addr;
   logic [DATA_W-1:0] dq_s;
   sector_e rd_sec_e, cap_sec_e, wr_sec_e;

   assign ctl_raw[CTL_CE]   = ce_n;
   assign ctl_raw[CTL_OE]   = oe_n;
   assign ctl_raw[CTL_WE]   = we_n;
   assign ctl_raw[CTL_RST]  = pin_rst_n;
   assign ctl_raw[CTL_WORD] = word_sel;
   assign bus_raw = {addr_pin, dq_in};

   pflash_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));

   pflash_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s));

   assign ce_s   = ctl_s[CTL_CE];
   assign oe_s   = ctl_s[CTL_OE];
   assign we_s   = ctl_s[CTL_WE];
   assign rp_s   = ctl_s[CTL_RST];
   assign word_s = ctl_s[CTL_WORD];
   assign clr    = !rp_s;
   assign addr_s = bus_s[BUS_W-1:DATA_W];
   assign dq_s   = bus_s[DATA_W-1:0];
   assign lsb_s  = dq_s[DATA_W-1];

   pflash_sector_map #(.ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS),
                       .PARAM_WORDS(PARAM_WORDS), .TOP_BOOT(TOP_BOOT)) u_rd_map (
      .addr(addr_s), .sector(rd_sec_e));

   pflash_sector_map #(.ADDR_W(ADDR_W), .BOOT_WORDS(BOOT_WORDS),
                       .PARAM_WORDS(PARAM_WORDS), .TOP_BOOT(TOP_BOOT)) u_wr_map (
      .addr(cap_addr), .sector(cap_sec_e));

   pflash_rd_path #(.DATA_W(DATA_W)) u_rd (
      .clr(clr), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .word_s(word_s),
      .lsb_s(lsb_s), .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe));

   pflash_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .ce_s(ce_s), .oe_s(oe_s),
      .we_s(we_s), .word_s(word_s), .lsb_s(lsb_s), .addr_s(addr_s),
      .dq_s(dq_s), .boot_lock(boot_lock), .cap_sector(cap_sec_e),
      .cap_addr(cap_addr), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_lsb(wr_lsb), .wr_byte(wr_byte), .wr_data(wr_data),
      .wr_sector(wr_sec_e));

   assign rd_addr   = addr_s;
   assign rd_sector = rd_sec_e;
   assign wr_sector = wr_sec_e;
endmodule

// File: rtl/pflash_bus_front_chk.sv
module pflash_bus_front_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_s,
   input logic              oe_s,
   input logic              we_s,
   input logic              rp_s,
   input logic              word_s,
   input logic              boot_lock,
   input logic [DATA_W-1:0] dq_oe,
   input logic              wr_valid,
   input logic              wr_byte,
   input logic [DATA_W-1:0] wr_data,
   input logic [1:0]        wr_sector
);
   localparam int HALF = DATA_W / 2;

   p_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_s && !ce_s && !oe_s && we_s) |-> (dq_oe[HALF-1:0] == {HALF{1'b1}}));

   p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rp_s || ce_s || oe_s || !we_s) |-> (dq_oe == '0));

   p_oe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(oe_s));

   p_byte_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !word_s |-> (dq_oe[DATA_W-1:HALF] == '0));

   p_byte_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_byte) |-> (wr_data[DATA_W-1:HALF] == '0));

   p_lockout_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !($past(boot_lock) && (wr_sector == 2'd0)));

   p_pin_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rp_s |=> !wr_valid);

   p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);
endmodule

bind pflash_bus_front pflash_bus_front_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
   .rp_s(rp_s), .word_s(word_s), .boot_lock(boot_lock), .dq_oe(dq_oe),
   .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_data(wr_data),
   .wr_sector(wr_sector));

// File: tb/sim_pflash_bus_front.sv
`timescale 1ns/1ps
module sim_pflash_bus_front;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pin_rst_n = 1'b1, word_sel = 1'b1;
   logic boot_lock = 1'b0;
   logic [18:0] addr_pin = '0;
   logic [15:0] dq_in = '0;

   logic [15:0] dq_out0, dq_oe0, rd_data0, wr_data0;
   logic [18:0] rd_addr0, wr_addr0;
   logic [1:0]  rd_sec0, wr_sec0;
   logic        wr_valid0, wr_lsb0, wr_byte0;
   logic [15:0] dq_out1, dq_oe1, rd_data1, wr_data1;
   logic [18:0] rd_addr1, wr_addr1;
   logic [1:0]  rd_sec1, wr_sec1;
   logic        wr_valid1, wr_lsb1, wr_byte1;

   int total = 0, bad = 0;
   int n0 = 0, n1 = 0;
   logic [18:0] la0; logic [15:0] ld0; logic [1:0] ls0; logic lb0, ll0;
   logic [18:0] la1; logic [1:0] ls1;
   bit done = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [15:0] mem_word(input logic [18:0] a);
      return {a[7:0] ^ 8'h3C, a[15:8] ^ {5'b0, a[18:16]}};
   endfunction
   assign rd_data0 = mem_word(rd_addr0);
   assign rd_data1 = mem_word(rd_addr1);

   pflash_bus_front #(.TOP_BOOT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .pin_rst_n(pin_rst_n), .word_sel(word_sel), .addr_pin(addr_pin),
      .dq_in(dq_in), .dq_out(dq_out0), .dq_oe(dq_oe0), .rd_addr(rd_addr0),
      .rd_data(rd_data0), .rd_sector(rd_sec0), .boot_lock(boot_lock),
      .wr_valid(wr_valid0), .wr_addr(wr_addr0), .wr_lsb(wr_lsb0),
      .wr_byte(wr_byte0), .wr_data(wr_data0), .wr_sector(wr_sec0));

   pflash_bus_front #(.TOP_BOOT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .pin_rst_n(pin_rst_n), .word_sel(word_sel), .addr_pin(addr_pin),
      .dq_in(dq_in), .dq_out(dq_out1), .dq_oe(dq_oe1), .rd_addr(rd_addr1),
      .rd_data(rd_data1), .rd_sector(rd_sec1), .boot_lock(boot_lock),
      .wr_valid(wr_valid1), .wr_addr(wr_addr1), .wr_lsb(wr_lsb1),
      .wr_byte(wr_byte1), .wr_data(wr_data1), .wr_sector(wr_sec1));

   // pulse monitor, sampled mid-cycle
   always @(negedge clk) begin
      if (wr_valid0) begin
         n0 <= n0 + 1; la0 <= wr_addr0; ld0 <= wr_data0; ls0 <= wr_sec0;
         lb0 <= wr_byte0; ll0 <= wr_lsb0;
      end
      if (wr_valid1) begin
         n1 <= n1 + 1; la1 <= wr_addr1; ls1 <= wr_sec1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cy(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [1:0] exp_bot(input logic [18:0] a);
      if (a <= 19'h01FFF) return 2'd0;
      if (a <= 19'h02FFF) return 2'd1;
      if (a <= 19'h03FFF) return 2'd2;
      return 2'd3;
   endfunction

   function automatic logic [1:0] exp_top(input logic [18:0] a);
      if (a >= 19'h7E000) return 2'd0;
      if (a >= 19'h7D000) return 2'd1;
      if (a >= 19'h7C000) return 2'd2;
      return 2'd3;
   endfunction

   // write strobe controlled cycle: chip select first, write strobe pulses
   task automatic we_write(input logic [18:0] a, input logic [15:0] d);
      addr_pin = a; dq_in = d; oe_n = 1'b1;
      ce_n = 1'b0; wait_cy(4);
      we_n = 1'b0; wait_cy(4);
      we_n = 1'b1; wait_cy(4);
      ce_n = 1'b1; wait_cy(4);
   endtask

   task automatic t_reset;
      chk(dq_oe0 == 16'h0, "R2 reset idle dq_oe", dq_oe0, 0);
      chk(n0 == 0 && n1 == 0, "R10 no pulse after reset", n0 + n1, 0);
   endtask

   task automatic t_read_word;
      addr_pin = 19'h12345; ce_n = 1'b0; oe_n = 1'b0; wait_cy(4);
      chk(dq_oe0 == 16'hFFFF, "R1 word read enables", dq_oe0, 16'hFFFF);
      chk(rd_addr0 == 19'h12345, "R1 read address", rd_addr0, 19'h12345);
      chk(dq_out0 == mem_word(19'h12345), "R1 read data", dq_out0, mem_word(19'h12345));
      addr_pin = 19'h40A5C; wait_cy(4);
      chk(dq_out0 == mem_word(19'h40A5C), "R1 read data second", dq_out0, mem_word(19'h40A5C));
      oe_n = 1'b1; wait_cy(4);
      chk(dq_oe0 == 16'h0, "R2 oe high tristate", dq_oe0, 0);
      oe_n = 1'b0; ce_n = 1'b1; wait_cy(4);
      chk(dq_oe0 == 16'h0, "R2 ce high tristate", dq_oe0, 0);
      ce_n = 1'b0; we_n = 1'b0; wait_cy(4);
      chk(dq_oe0 == 16'h0, "R2 we low tristate", dq_oe0, 0);
      we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; wait_cy(4);
   endtask

   task automatic t_we_write;
      int b0 = n0;
      we_write(19'h05000, 16'h1234);
      wait_cy(2);
      chk(n0 == b0 + 1, "R3 single pulse we-controlled", n0 - b0, 1);
      chk(la0 == 19'h05000, "R3 write address", la0, 19'h05000);
      chk(ld0 == 16'h1234, "R3 write data", ld0, 16'h1234);
      chk(lb0 == 1'b0, "R3 word write flag", lb0, 0);
   endtask

   task automatic t_ce_write;
      int b0 = n0;
      // write strobe low first, chip select pulses
      addr_pin = 19'h01234; dq_in = 16'h0F0F; we_n = 1'b0; wait_cy(4);
      addr_pin = 19'h02345; wait_cy(4);
      ce_n = 1'b0; wait_cy(4);
      addr_pin = 19'h03456; wait_cy(4);
      dq_in = 16'hBEEF; wait_cy(4);
      ce_n = 1'b1; wait_cy(4);
      dq_in = 16'h1111; wait_cy(4);
      we_n = 1'b1; wait_cy(4);
      chk(n0 == b0 + 1, "R3 single pulse ce-controlled", n0 - b0, 1);
      chk(la0 == 19'h02345, "R4 address at later fall", la0, 19'h02345);
      chk(ld0 == 16'hBEEF, "R5 data at first rise", ld0, 16'hBEEF);
      chk(ls0 == 2'd1, "R7 captured sector param1", ls0, 1);
      // falls on write strobe, first rise on write strobe, ce rises later
      b0 = n0;
      addr_pin = 19'h06000; dq_in = 16'h2222; ce_n = 1'b0; wait_cy(4);
      we_n = 1'b0; wait_cy(4);
      addr_pin = 19'h07777; dq_in = 16'hCAFE; wait_cy(4);
      we_n = 1'b1; wait_cy(4);
      dq_in = 16'h3333; wait_cy(4);
      ce_n = 1'b1; wait_cy(4);
      chk(n0 == b0 + 1, "R3 pulse count mixed", n0 - b0, 1);
      chk(la0 == 19'h06000, "R4 address held after fall", la0, 19'h06000);
      chk(ld0 == 16'hCAFE, "R5 later data ignored", ld0, 16'hCAFE);
      // output enable low: no write
      b0 = n0;
      oe_n = 1'b0; ce_n = 1'b0; wait_cy(4);
      we_n = 1'b0; wait_cy(4); we_n = 1'b1; wait_cy(4);
      ce_n = 1'b1; oe_n = 1'b1; wait_cy(6);
      chk(n0 == b0, "R3 no pulse with oe low", n0 - b0, 0);
   endtask

   task automatic t_byte;
      int b0;
      word_sel = 1'b0; addr_pin = 19'h00321; dq_in = 16'h8000;
      ce_n = 1'b0; oe_n = 1'b0; wait_cy(4);
      chk(dq_oe0 == 16'h00FF, "R6 byte read enables", dq_oe0, 16'h00FF);
      chk(dq_out0[7:0] == mem_word(19'h00321)[15:8], "R6 high byte select",
          dq_out0[7:0], mem_word(19'h00321)[15:8]);
      dq_in = 16'h0000; wait_cy(4);
      chk(dq_out0[7:0] == mem_word(19'h00321)[7:0], "R6 low byte select",
          dq_out0[7:0], mem_word(19'h00321)[7:0]);
      ce_n = 1'b1; oe_n = 1'b1; wait_cy(4);
      b0 = n0;
      we_write(19'h04444, 16'hFFAB);
      wait_cy(2);
      chk(n0 == b0 + 1, "R6 byte write pulse", n0 - b0, 1);
      chk(ld0 == 16'h00AB, "R6 byte write data", ld0, 16'h00AB);
      chk(ll0 == 1'b1 && lb0 == 1'b1, "R6 byte lsb and flag", {ll0, lb0}, 2'b11);
      word_sel = 1'b1; wait_cy(4);
   endtask

   task automatic t_sectors;
      logic [18:0] pts [14] = '{19'h00000, 19'h01FFF, 19'h02000, 19'h02FFF,
                                19'h03000, 19'h03FFF, 19'h04000, 19'h7FFFF,
                                19'h7E000, 19'h7DFFF, 19'h7D000, 19'h7CFFF,
                                19'h7C000, 19'h7BFFF};
      for (int i = 0; i < 14; i++) begin
         addr_pin = pts[i]; wait_cy(4);
         chk(rd_sec0 == exp_bot(pts[i]), "R7 bottom-boot sector", rd_sec0, exp_bot(pts[i]));
         chk(rd_sec1 == exp_top(pts[i]), "R8 top-boot sector", rd_sec1, exp_top(pts[i]));
      end
   endtask

   task automatic t_lock;
      int b0 = n0, b1 = n1;
      boot_lock = 1'b1;
      we_write(19'h00100, 16'h5555);
      wait_cy(2);
      chk(n0 == b0, "R9 bottom boot write blocked", n0 - b0, 0);
      chk(n1 == b1 + 1 && ls1 == 2'd3, "R9 top main write passes", n1 - b1, 1);
      b0 = n0; b1 = n1;
      we_write(19'h7E100, 16'h6666);
      wait_cy(2);
      chk(n0 == b0 + 1 && ls0 == 2'd3, "R9 bottom main write passes", n0 - b0, 1);
      chk(n1 == b1, "R9 top boot write blocked", n1 - b1, 0);
      boot_lock = 1'b0;
      b0 = n0;
      we_write(19'h00100, 16'h7777);
      wait_cy(2);
      chk(n0 == b0 + 1 && ls0 == 2'd0, "R7 boot write unlocked", n0 - b0, 1);
   endtask

   task automatic t_pin_reset;
      int b0 = n0;
      addr_pin = 19'h05555; dq_in = 16'h9999;
      ce_n = 1'b0; wait_cy(4); we_n = 1'b0; wait_cy(4);
      pin_rst_n = 1'b0; wait_cy(4);
      we_n = 1'b1; ce_n = 1'b1; wait_cy(4);
      ce_n = 1'b0; oe_n = 1'b0; wait_cy(4);
      chk(dq_oe0 == 16'h0, "R10 no drive in pin reset", dq_oe0, 0);
      pin_rst_n = 1'b1; wait_cy(4);
      chk(n0 == b0, "R10 aborted write no pulse", n0 - b0, 0);
      chk(dq_oe0 == 16'hFFFF && dq_out0 == mem_word(19'h05555),
          "R10 read after release", dq_out0, mem_word(19'h05555));
      ce_n = 1'b1; oe_n = 1'b1; wait_cy(4);
   endtask

   task automatic t_back_to_back;
      int b0 = n0;
      we_write(19'h10000, 16'hA001);
      we_write(19'h10001, 16'hA002);
      wait_cy(2);
      chk(n0 == b0 + 2, "R11 two writes two pulses", n0 - b0, 2);
      chk(la0 == 19'h10001 && ld0 == 16'hA002, "R11 last write values", ld0, 16'hA002);
   endtask

   initial begin
      wait_cy(3);
      rst_n = 1'b1;
      wait_cy(4);
      t_reset();
      t_read_word();
      t_we_write();
      t_ce_write();
      t_byte();
      t_sectors();
      t_lock();
      t_pin_reset();
      t_back_to_back();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule